// File: doc/BRIEF.md
# Audio master-mode clock generator

This block produces the two clocks a serial audio port needs when it runs as clock master: a bit clock and a frame clock. Both come from a single oversampled master clock by integer division. No PLL is involved. A 2-bit ratio code states how many master-clock periods make one sample period: 256, 512 or 1024. A second 2-bit code states how many bit-clock periods make one frame: 32 or 64. The other two values of that second code are reserved.

The block is clocked directly by the master clock. Two converter power enables gate it. While both are low, the dividers are held at zero and both clocks stay low. When either enable rises, a frame starts at once. A change to either select code restarts the frame from its beginning. A reserved bit-clock code stops both clocks and raises a configuration-error flag.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst` is high, `bclk`, `lrck` and `cfg_bad` read 0 after each clock edge. After reset, the registered select codes are `fs_sel`=00 and `bck_sel`=01.
- R2: The frame length in master-clock cycles is set by `fs_sel`: 00 gives 256, 11 gives 256, 10 gives 512 and 01 gives 1024. `lrck` repeats with exactly that period.
- R3: With `bck_sel`=01, each frame holds 32 bit-clock periods. `bclk` then has a period of frame/32 master cycles and a 50% duty cycle, and it is low in the first half of each period.
- R4: With `bck_sel`=10, each frame holds 64 bit-clock periods. `bclk` then has a period of frame/64 master cycles with the same 50% shape.
- R5: `lrck` is low for the first half of each frame and high for the second half. Every `lrck` edge coincides with a falling edge of `bclk`, so `lrck` changes level every 16 bit-clock periods in 32-per-frame mode and every 32 in 64-per-frame mode.
- R6: With `bck_sel` at 00 or 11, `bclk` and `lrck` stay low. `cfg_bad` equals 1 after the first clock edge that samples the reserved code, and equals 0 after the first edge that samples a valid code.
- R7: When either select code differs from its value at the previous edge, the edge that samples the new value forces both clocks low and zeroes the divider. The next edge begins a frame from its start.
- R8: When `pwr_en_a` and `pwr_en_b` are both low, the edge that samples them drives both clocks low and holds the divider at zero. At the first edge where either enable is high, the frame starts from its beginning, with no extra restart cycle.
- R9: Outputs are registered. The value seen after the n-th edge of a running frame is the phase of master cycle n-1 in that frame, counting the edge that started the frame as the 0th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en_a | input | 1 | Power enable of the first converter channel |
| pwr_en_b | input | 1 | Power enable of the second converter channel |
| fs_sel | input | 2 | Master-to-sample ratio code |
| bck_sel | input | 2 | Bit clocks per frame code |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Frame (word-select) clock, one period per sample |
| cfg_bad | output | 1 | Reserved bit-clock code selected |

## Verification
The bench targets these cases:

- **Ratio codes.** Codes 00 and 11 must both yield 256-cycle frames, and 01 must yield 1024 rather than 512. A decoder that treats the code as monotonic would stretch or shrink the frame, and every `lrck` edge would then land at the wrong place.
- **Mid-frame select changes.** The bench changes the selects partway through a frame. A design that does not restart would carry the old phase into the new ratio and misplace every following edge.
- **Reserved codes.** A design that kept dividing on a reserved code, or never raised the flag, is caught on both counts.
- **Power cycling.** The bench turns power off and on with one enable at a time. A design that left clocks running while powered down, or that added a restart cycle on power-up, would shift the whole frame by one master cycle.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  localparam int LOG_W = 4;
  typedef logic [LOG_W-1:0] log_t;

  // log2 of master cycles per frame for a ratio code
  function automatic log_t frame_log2(input logic [1:0] code);
    case (code)
      2'b01:   frame_log2 = log_t'(10);
      2'b10:   frame_log2 = log_t'(9);
      default: frame_log2 = log_t'(8);
    endcase
  endfunction

  function automatic logic bck_code_ok(input logic [1:0] code);
    bck_code_ok = (code == 2'b01) || (code == 2'b10);
  endfunction

  // log2 of bit clocks per frame
  function automatic log_t bck_log2(input logic [1:0] code);
    bck_log2 = (code == 2'b01) ? log_t'(5) : log_t'(6);
  endfunction
endpackage

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import audio_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr,
  input  logic [1:0] fs_sel,
  input  logic [1:0] bck_sel,
  output logic       restart,
  output log_t       frame_lg,
  output log_t       half_lg,
  output logic       cfg_bad
);
  logic [1:0] fs_q;
  logic [1:0] bck_q;
  logic       changed;
  logic       code_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q    <= 2'b00;
      bck_q   <= 2'b01;
      cfg_bad <= 1'b0;
    end else begin
      fs_q    <= fs_sel;
      bck_q   <= bck_sel;
      cfg_bad <= !bck_code_ok(bck_sel);
    end
  end

  always_comb begin
    code_ok  = bck_code_ok(bck_sel);
    changed  = (fs_sel != fs_q) || (bck_sel != bck_q);
    // powered down, reconfigured or reserved: divider parks at zero
    restart  = !pwr || changed || !code_ok;
    frame_lg = frame_log2(fs_sel);
    half_lg  = frame_lg - bck_log2(bck_sel) - log_t'(1);
  end

  // R7: a code that differs from the last sampled one always restarts
  p_change_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    (fs_sel != fs_q) |-> restart);
endmodule

// File: rtl/clkgen_phase.sv
module clkgen_phase
  import audio_clkgen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  log_t             frame_lg,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] wrap_mask;

  always_comb wrap_mask = (CNT_W'(1) << frame_lg) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= (cnt + CNT_W'(1)) & wrap_mask;
  end

  // R7: a cleared divider restarts from phase zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/clkgen_shape.sv
module clkgen_shape
  import audio_clkgen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  input  log_t             frame_lg,
  input  log_t             half_lg,
  output logic             bclk,
  output logic             lrck
);
  log_t lr_idx;

  always_comb lr_idx = frame_lg - log_t'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bclk <= 1'b0;
      lrck <= 1'b0;
    end else begin
      bclk <= cnt[half_lg];
      lrck <= cnt[lr_idx];
    end
  end

  // R5: the frame clock rises only together with a bit-clock fall
  p_lrck_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lrck) |-> $fell(bclk));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_en_a,
  input  logic       pwr_en_b,
  input  logic [1:0] fs_sel,
  input  logic [1:0] bck_sel,
  output logic       bclk,
  output logic       lrck,
  output logic       cfg_bad
);
  logic             pwr;
  logic             restart;
  log_t             frame_lg;
  log_t             half_lg;
  logic [CNT_W-1:0] cnt;

  always_comb pwr = pwr_en_a || pwr_en_b;

  clkgen_cfg u_cfg (
    .clk(clk), .rst(rst), .pwr(pwr), .fs_sel(fs_sel), .bck_sel(bck_sel),
    .restart(restart), .frame_lg(frame_lg), .half_lg(half_lg), .cfg_bad(cfg_bad)
  );

  clkgen_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .clr(restart), .frame_lg(frame_lg), .cnt(cnt)
  );

  clkgen_shape #(.CNT_W(CNT_W)) u_shape (
    .clk(clk), .rst(rst), .clr(restart), .cnt(cnt), .frame_lg(frame_lg),
    .half_lg(half_lg), .bclk(bclk), .lrck(lrck)
  );

  // R6: a flagged configuration leaves both clocks quiet
  p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> (!bclk && !lrck));

  // R8: powered down means both clocks low one edge later
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en_a && !pwr_en_b) |=> (!bclk && !lrck));

  // R1: outputs low after a reset edge
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!bclk && !lrck && !cfg_bad));
endmodule

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_en_a = 1'b1;
  logic       pwr_en_b = 1'b1;
  logic [1:0] fs_sel = 2'b00;
  logic [1:0] bck_sel = 2'b01;
  logic       bclk, lrck, cfg_bad;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit q_b[$];
  bit q_l[$];
  bit q_f[$];
  int q_r[$];

  always #10 clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk(clk), .rst(rst), .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b),
    .fs_sel(fs_sel), .bck_sel(bck_sel), .bclk(bclk), .lrck(lrck), .cfg_bad(cfg_bad)
  );

  function automatic string req_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int frame_bits(input logic [1:0] fs);
    if (fs == 2'b01) return 10;
    if (fs == 2'b10) return 9;
    return 8;
  endfunction

  function automatic bit code_ok(input logic [1:0] b);
    return (b == 2'b01) || (b == 2'b10);
  endfunction

  // which = 0 gives the bit clock, 1 the frame clock, at frame phase idx
  function automatic bit model(input logic [1:0] fs, input logic [1:0] b,
                               input bit on, input int idx, input int which);
    int fb, hb, ph;
    if (!on || !code_ok(b) || idx < 0) return 1'b0;
    fb = frame_bits(fs);
    hb = fb - ((b == 2'b01) ? 5 : 6) - 1;
    ph = idx % (1 << fb);
    if (which == 0) return ((ph >> hb) & 1) == 1;
    return ((ph >> (fb - 1)) & 1) == 1;
  endfunction

  // driver: one scoreboard item per master cycle
  task automatic seg(input logic [1:0] fs, input logic [1:0] b, input logic [1:0] pe,
                     input int lead, input int n, input int tag);
    bit prev_l = 1'b0;
    for (int k = 0; k < n; k++) begin
      bit eb, el;
      int t;
      @(negedge clk);
      if (k == 0) begin
        rst = 1'b0; fs_sel = fs; bck_sel = b;
        pwr_en_a = pe[1]; pwr_en_b = pe[0];
      end
      eb = model(fs, b, pe != 2'b00, k - lead, 0);
      el = model(fs, b, pe != 2'b00, k - lead, 1);
      t = tag;
      if (lead == 1 && k < 2) t = 7;         // R7 restart window
      else if (k > 0 && el != prev_l) t = 5; // R5 frame-clock edge
      prev_l = el;
      q_b.push_back(eb); q_l.push_back(el);
      q_f.push_back(!code_ok(b)); q_r.push_back(t);
    end
  endtask

  // monitor: compares mid-cycle, well away from the edges
  always @(posedge clk) begin
    #5;
    if (q_b.size() > 0) begin
      bit eb, el, ef;
      int t;
      eb = q_b.pop_front(); el = q_l.pop_front();
      ef = q_f.pop_front(); t = q_r.pop_front();
      n_checks++;
      if (bclk !== eb || lrck !== el || cfg_bad !== ef) begin
        n_fail++;
        $display("FAIL %s: bclk/lrck/flag = %0d%0d%0d expected %0d%0d%0d at %0t",
                 req_name(t), bclk, lrck, cfg_bad, eb, el, ef, $time);
      end
    end
  end

  initial begin
    // R1: reset holds everything low
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      q_b.push_back(1'b0); q_l.push_back(1'b0); q_f.push_back(1'b0); q_r.push_back(1);
    end
    seg(2'b00, 2'b01, 2'b11, 0, 600, 3);  // R3 default after reset, R9 latency
    seg(2'b00, 2'b10, 2'b11, 1, 600, 4);  // R4 64 per frame
    seg(2'b01, 2'b10, 2'b11, 1, 2100, 2); // R2 1024
    seg(2'b10, 2'b01, 2'b11, 1, 1100, 2); // R2 512
    seg(2'b11, 2'b01, 2'b11, 1, 600, 2);  // R2 code 11 is 256
    seg(2'b01, 2'b01, 2'b11, 1, 2100, 3); // R3 at 1024
    seg(2'b01, 2'b00, 2'b11, 1, 50, 6);   // R6 reserved 00
    seg(2'b01, 2'b11, 2'b11, 1, 50, 6);   // R6 reserved 11
    seg(2'b10, 2'b10, 2'b11, 1, 1100, 7); // R7 recovery
    seg(2'b10, 2'b10, 2'b00, 0, 50, 8);   // R8 off
    seg(2'b10, 2'b10, 2'b10, 0, 1100, 8); // R8 one enable
    seg(2'b10, 2'b10, 2'b00, 0, 30, 8);
    seg(2'b01, 2'b10, 2'b00, 0, 30, 8);   // R8 reconfigure while off
    seg(2'b01, 2'b10, 2'b01, 0, 1100, 8); // R8 other enable
    seg(2'b00, 2'b01, 2'b11, 1, 300, 9);  // R9
    while (q_b.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9: watchdog expired, got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule